// File: doc/BRIEF.md
# MSI Vector Table P/Q State Engine

This block turns a trigger for one message-signalled interrupt source into a delivery decision. It takes a source number and works out where that source's entry sits in a vector table held in system memory. It fetches the 64-bit entry through a simple request/acknowledge memory port. From the entry it reads a two-bit pending/queued (P/Q) coalescing state, the priority, the target server and a generation bit.

The P/Q state decides the outcome. The engine either marks the entry pending and presents the interrupt, marks it queued, or drops the event. All state changes are single-byte writes back into the entry. A priority of all ones masks the source, so the event is queued rather than lost.

A force input makes the engine act as if P/Q were clear. A resend path uses it to re-deliver events that a presenter turned away. The engine works on one request at a time. Configuration supplies the table base, its length in entries, an enable, and a choice of 16-byte or 128-byte entry stride.

Top module: `msi_pq_engine`

## Requirements
- R1: After reset `busy`, `mem_req` and `irq_valid` are low.
- R2: When `cfg_tbl_en` is 0, a trigger causes no memory access and no presentation, and `busy` stays low.
- R3: A source number greater than or equal to `cfg_tbl_len` is rejected with no memory access and no presentation; source `cfg_tbl_len-1` is accepted.
- R4: The entry is read at one 8-byte read. Its address is the base with its low 7 bits cleared, plus 16×source when `cfg_big_entry` is 0 or 128×source when it is 1. `mem_req` stays high until `mem_ack`.
- R5: The entry is big-endian: the byte at the entry address is `mem_rdata[63:56]`. P is bit 24, the generation bit is bit 25, Q is bit 16, and priority is bits 7:0. The raw server is bits 63:48, and the presented server is that field shifted right by 2 (bits 63:50).
- R6: With P=0, Q=0 and a priority other than 0xFF, the engine writes one byte at entry+4 with value 1 | (gen<<1). After that write succeeds, it pulses `irq_valid` for one cycle with server, source and priority.
- R7: With P=0, Q=0 and priority 0xFF, the engine writes one byte at entry+5 with value 1, and there is no presentation.
- R8: With P=1 and Q=0, the engine writes one byte at entry+5 with value 1, and there is no presentation.
- R9: With Q=1 (any P), there is no write and no presentation.
- R10: With `trig_force` high, the stored P/Q bits are treated as 00.
- R11: `busy` is high from acceptance until the request ends; triggers seen while busy are ignored.
- R12: A response with `mem_err` high ends the request with no further write and no presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger strobe for one source |
| trig_src | input | SRC_W | Source number |
| trig_force | input | 1 | Treat stored P/Q as 00 (resend) |
| busy | output | 1 | Request in progress |
| cfg_tbl_en | input | 1 | Vector table enable |
| cfg_tbl_base | input | ADDR_W | Table base address (low 7 bits ignored) |
| cfg_tbl_len | input | SRC_W+1 | Number of table entries |
| cfg_big_entry | input | 1 | 1: 128-byte stride, 0: 16-byte stride |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: byte write, 0: 8-byte read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completion failed (with ack) |
| mem_rdata | input | 64 | Read data, big-endian |
| irq_valid | output | 1 | One-cycle presentation pulse |
| irq_server | output | 14 | Target server |
| irq_src | output | SRC_W | Presented source number |
| irq_prio | output | 8 | Presented priority |

## Verification
The bench sweeps every P/Q combination against masked and unmasked priority, with and without force, for each source of an eight-entry table at both strides. It computes the expected address, byte value and presentation for each case. A mix-up of the P and Q byte offsets, a missing shift of the server, or a forced resend that still honours Q would each appear as a wrong write address or a wrong or missing pulse. The bench also probes the last legal source and the first illegal one, a disabled table, and a misaligned base. Its remaining cases cover a read error, a write error and a second trigger arriving while busy. A design that still wrote or presented after an error, or that restarted on the second trigger, would produce extra memory traffic that the bench counts.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;
  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_SET_Q = 2'd1,
    ACT_SET_P = 2'd2
  } pq_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_SEND = 2'd3
  } pq_state_e;
endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr #(
  parameter int ADDR_W     = 16,
  parameter int SRC_W      = 6,
  parameter int BASE_ALIGN = 7
) (
  input  logic              tbl_en,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SRC_W:0]    tbl_len,
  input  logic              big_entry,
  input  logic [SRC_W-1:0]  src,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              entry_ok
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((1 << BASE_ALIGN) - 1);

  logic [ADDR_W-1:0] src_ext;
  assign src_ext    = ADDR_W'(src);
  assign entry_addr = (tbl_base & BASE_MASK) +
                      (big_entry ? (src_ext << 7) : (src_ext << 4));
  assign entry_ok   = tbl_en && ({1'b0, src} < tbl_len);
endmodule

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
  import msi_pq_pkg::*;
#(
  parameter int P_BIT    = 24,
  parameter int GEN_BIT  = 25,
  parameter int Q_BIT    = 16,
  parameter int PRIO_LSB = 0,
  parameter int PRIO_W   = 8,
  parameter int SERV_LSB = 48,
  parameter int SERV_W   = 16,
  parameter int LINK_W   = 2,
  localparam int PSERV_W = SERV_W - LINK_W
) (
  input  logic [63:0]        entry,
  input  logic               force_pq,
  output logic               gen,
  output logic [PRIO_W-1:0]  prio,
  output logic [PSERV_W-1:0] server,
  output pq_act_e            act
);
  logic p_bit, q_bit, masked;
  logic unused_bits;

  assign unused_bits = ^entry;
  assign p_bit  = force_pq ? 1'b0 : entry[P_BIT];
  assign q_bit  = force_pq ? 1'b0 : entry[Q_BIT];
  assign gen    = entry[GEN_BIT];
  assign prio   = entry[PRIO_LSB +: PRIO_W];
  assign server = entry[SERV_LSB + LINK_W +: PSERV_W];
  assign masked = &prio;

  always_comb begin
    unique case ({p_bit, q_bit})
      2'b00:   act = masked ? ACT_SET_Q : ACT_SET_P;
      2'b10:   act = ACT_SET_Q;
      default: act = ACT_DROP;
    endcase
  end
endmodule

// File: rtl/msi_pq_engine.sv
module msi_pq_engine
  import msi_pq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SRC_W      = 6,
  parameter int BASE_ALIGN = 7,
  parameter int P_BIT      = 24,
  parameter int GEN_BIT    = 25,
  parameter int Q_BIT      = 16,
  parameter int PRIO_LSB   = 0,
  parameter int PRIO_W     = 8,
  parameter int SERV_LSB   = 48,
  parameter int SERV_W     = 16,
  parameter int LINK_W     = 2,
  localparam int PSERV_W   = SERV_W - LINK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  input  logic               trig_force,
  output logic               busy,
  input  logic               cfg_tbl_en,
  input  logic [ADDR_W-1:0]  cfg_tbl_base,
  input  logic [SRC_W:0]     cfg_tbl_len,
  input  logic               cfg_big_entry,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic               mem_ack,
  input  logic               mem_err,
  input  logic [63:0]        mem_rdata,
  output logic               irq_valid,
  output logic [PSERV_W-1:0] irq_server,
  output logic [SRC_W-1:0]   irq_src,
  output logic [PRIO_W-1:0]  irq_prio
);
  // Byte offsets of the P and Q bytes follow from the big-endian bit positions
  localparam int P_OFS = 7 - (P_BIT / 8);
  localparam int Q_OFS = 7 - (Q_BIT / 8);

  pq_state_e          state_q;
  logic [SRC_W-1:0]   src_q;
  logic               force_q;
  logic               send_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         wdata_q;

  logic [ADDR_W-1:0]  entry_addr;
  logic               entry_ok;
  logic               dec_gen;
  logic [PRIO_W-1:0]  dec_prio;
  logic [PSERV_W-1:0] dec_server;
  pq_act_e            dec_act;

  msi_entry_addr #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .BASE_ALIGN(BASE_ALIGN)
  ) u_addr (
    .tbl_en(cfg_tbl_en), .tbl_base(cfg_tbl_base), .tbl_len(cfg_tbl_len),
    .big_entry(cfg_big_entry), .src(trig_src),
    .entry_addr(entry_addr), .entry_ok(entry_ok)
  );

  msi_entry_decode #(
    .P_BIT(P_BIT), .GEN_BIT(GEN_BIT), .Q_BIT(Q_BIT), .PRIO_LSB(PRIO_LSB),
    .PRIO_W(PRIO_W), .SERV_LSB(SERV_LSB), .SERV_W(SERV_W), .LINK_W(LINK_W)
  ) u_dec (
    .entry(mem_rdata), .force_pq(force_q),
    .gen(dec_gen), .prio(dec_prio), .server(dec_server), .act(dec_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      src_q      <= '0;
      force_q    <= 1'b0;
      send_q     <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      irq_server <= '0;
      irq_src    <= '0;
      irq_prio   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_valid && entry_ok) begin
            src_q   <= trig_src;
            force_q <= trig_force;
            addr_q  <= entry_addr;
            send_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ack) begin
            if (mem_err || dec_act == ACT_DROP) begin
              state_q <= ST_IDLE;
            end else if (dec_act == ACT_SET_Q) begin
              addr_q  <= addr_q + ADDR_W'(Q_OFS);
              wdata_q <= 8'h01;
              state_q <= ST_WR;
            end else begin
              addr_q     <= addr_q + ADDR_W'(P_OFS);
              wdata_q    <= {6'b0, dec_gen, 1'b1};
              send_q     <= 1'b1;
              irq_server <= dec_server;
              irq_src    <= src_q;
              irq_prio   <= dec_prio;
              state_q    <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_ack) begin
            state_q <= (!mem_err && send_q) ? ST_SEND : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign irq_valid = (state_q == ST_SEND);

  // R1: outputs quiet in the cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !mem_req && !irq_valid));

  // R4: a request is held until it is acknowledged
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: writes only land on the P or Q byte of an aligned entry
  assert_write_offset_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[3:0] == 4'(P_OFS) || mem_addr[3:0] == 4'(Q_OFS)));

  // R6: a presentation follows a successful write
  assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(mem_ack && !mem_err && mem_we));

  // R7: a masked priority is never presented
  assert_no_masked_irq_R7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_prio != '1));

  // R8: the Q byte is always written with 1
  assert_q_value_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr[3:0] == 4'(Q_OFS)) |-> (mem_wdata == 8'h01));

  // R11: a trigger while busy does not disturb the request in flight
  assert_busy_ignores_trig_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && trig_valid) |=> ($stable(src_q) && $stable(force_q)));

  // R12: an error response ends the request
  assert_err_ends_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_err) |=> (!mem_req && !irq_valid));
endmodule

// File: tb/msi_pq_engine_tb.sv
module msi_pq_engine_tb;
  localparam int ADDR_W = 16;
  localparam int SRC_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              trig_valid = 1'b0;
  logic [SRC_W-1:0]  trig_src = '0;
  logic              trig_force = 1'b0;
  logic              busy;
  logic              cfg_tbl_en = 1'b1;
  logic [ADDR_W-1:0] cfg_tbl_base = 16'h0100;
  logic [SRC_W:0]    cfg_tbl_len = 7'd8;
  logic              cfg_big_entry = 1'b0;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic              mem_ack, mem_err;
  logic [63:0]       mem_rdata;
  logic              irq_valid;
  logic [13:0]       irq_server;
  logic [SRC_W-1:0]  irq_src;
  logic [7:0]        irq_prio;

  msi_pq_engine u_dut (
    .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_src(trig_src),
    .trig_force(trig_force), .busy(busy), .cfg_tbl_en(cfg_tbl_en),
    .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
    .cfg_big_entry(cfg_big_entry), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .irq_valid(irq_valid),
    .irq_server(irq_server), .irq_src(irq_src), .irq_prio(irq_prio)
  );

  // Memory model and observation counters
  logic [7:0] mem [0:4095];
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0;
  int last_raddr = 0, last_waddr = 0, last_wdata = 0;
  int got_srv = 0, got_src = 0, got_pri = 0;
  int err_mode = 0; // 1: fail reads, 2: fail writes
  int checks = 0, errors = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (!mem_we) begin
        mem_err <= (err_mode == 1);
        for (int k = 0; k < 8; k++)
          mem_rdata[63-8*k -: 8] <= mem[(int'(mem_addr) + k) % 4096];
        rd_cnt <= rd_cnt + 1;
        last_raddr <= int'(mem_addr);
      end else begin
        mem_err <= (err_mode == 2);
        if (err_mode != 2) mem[int'(mem_addr) % 4096] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_waddr <= int'(mem_addr);
        last_wdata <= int'(mem_wdata);
      end
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
    if (!rst && irq_valid) begin
      irq_cnt <= irq_cnt + 1;
      got_srv <= int'(irq_server);
      got_src <= int'(irq_src);
      got_pri <= int'(irq_prio);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_entry(input int addr, input bit p, input bit q, input bit g,
                           input int pri, input int srv);
    logic [63:0] e;
    e = (64'(srv & 16'hFFFF) << 48) | (64'(g) << 25) | (64'(p) << 24) |
        (64'(q) << 16) | 64'(pri & 8'hFF);
    for (int k = 0; k < 8; k++) mem[(addr + k) % 4096] = e[63-8*k -: 8];
  endtask

  task automatic run(input int src, input bit frc);
    @(negedge clk);
    trig_src = SRC_W'(src); trig_force = frc; trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    if (busy) chk(1'b0, "R11 busy stuck", 1, 0);
    @(negedge clk);
  endtask

  int r0, w0, i0, base_eff, ea;
  int pri, srv, eff;
  bit g;

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !irq_valid, "R1 reset state", int'({busy, mem_req, irq_valid}), 0);

    // Sweep: stride x source x stored P/Q x mask x force
    base_eff = 16'h0100;
    for (int big = 0; big < 2; big++) begin
      cfg_big_entry = big[0];
      for (int s = 0; s < 8; s++)
        for (int pq = 0; pq < 4; pq++)
          for (int m = 0; m < 2; m++)
            for (int f = 0; f < 2; f++) begin
              ea  = base_eff + (big != 0 ? 128 * s : 16 * s);
              pri = (m != 0) ? 255 : (s * 3 + 1);
              srv = 16'h1234 + s * 4 + pq;
              g   = s[0] ^ big[0];
              put_entry(ea, pq[1], pq[0], g, pri, srv);
              r0 = rd_cnt; w0 = wr_cnt; i0 = irq_cnt;
              run(s, f[0]);
              eff = (f != 0) ? 0 : pq;
              chk(rd_cnt == r0 + 1, "R4 one read", rd_cnt - r0, 1);
              chk(last_raddr == ea, "R4 entry address", last_raddr, ea);
              if (eff == 0 && m == 0) begin
                // R6 / R10: P write then presentation
                chk(wr_cnt == w0 + 1, "R6 one write", wr_cnt - w0, 1);
                chk(last_waddr == ea + 4, "R6 P byte address", last_waddr, ea + 4);
                chk(last_wdata == (1 | (int'(g) << 1)), "R6 P byte value", last_wdata, 1 | (int'(g) << 1));
                chk(irq_cnt == i0 + 1, "R6 R10 one presentation", irq_cnt - i0, 1);
                chk(got_srv == (srv >> 2), "R5 server shift", got_srv, srv >> 2);
                chk(got_src == s, "R6 source", got_src, s);
                chk(got_pri == pri, "R5 priority", got_pri, pri);
              end else if (eff == 0 || eff == 2) begin
                // R7 masked / R8 pending: Q write only
                chk(wr_cnt == w0 + 1, "R7 R8 one write", wr_cnt - w0, 1);
                chk(last_waddr == ea + 5, "R7 R8 Q byte address", last_waddr, ea + 5);
                chk(last_wdata == 1, "R7 R8 Q byte value", last_wdata, 1);
                chk(mem[(ea + 5) % 4096] == 8'h01, "R8 Q byte stored", int'(mem[(ea + 5) % 4096]), 1);
                chk(irq_cnt == i0, "R7 R8 no presentation", irq_cnt - i0, 0);
              end else begin
                chk(wr_cnt == w0, "R9 no write", wr_cnt - w0, 0);
                chk(irq_cnt == i0, "R9 no presentation", irq_cnt - i0, 0);
              end
            end
    end
    cfg_big_entry = 1'b0;

    // R3: first out-of-range source, table length 8
    r0 = rd_cnt; i0 = irq_cnt;
    run(8, 1'b0);
    chk(rd_cnt == r0, "R3 out of bounds no read", rd_cnt - r0, 0);
    chk(irq_cnt == i0, "R3 out of bounds no irq", irq_cnt - i0, 0);

    // R2: disabled table
    cfg_tbl_en = 1'b0;
    put_entry(16'h0100 + 16, 0, 0, 0, 5, 16'h0040);
    r0 = rd_cnt; i0 = irq_cnt;
    @(negedge clk);
    trig_src = 6'd1; trig_force = 1'b0; trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    chk(!busy, "R2 disabled stays idle", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(rd_cnt == r0 && irq_cnt == i0, "R2 disabled no access", rd_cnt - r0, 0);
    cfg_tbl_en = 1'b1;

    // R4: misaligned base has low 7 bits ignored
    cfg_tbl_base = 16'h0155;
    put_entry(16'h0100 + 32, 0, 0, 0, 7, 16'h0080);
    run(2, 1'b0);
    chk(last_raddr == 16'h0120, "R4 base masking", last_raddr, 16'h0120);
    cfg_tbl_base = 16'h0100;

    // R11: second trigger while busy is ignored
    put_entry(16'h0100 + 16, 0, 0, 1, 9, 16'h0100);
    put_entry(16'h0100 + 48, 0, 0, 0, 9, 16'h0200);
    r0 = rd_cnt; i0 = irq_cnt;
    @(negedge clk);
    trig_src = 6'd1; trig_valid = 1'b1;
    @(negedge clk);
    trig_src = 6'd3;
    chk(busy, "R11 busy after accept", int'(busy), 1);
    @(negedge clk);
    trig_valid = 1'b0;
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rd_cnt == r0 + 1, "R11 single read", rd_cnt - r0, 1);
    chk(got_src == 1 && irq_cnt == i0 + 1, "R11 first source only", got_src, 1);

    // R12: read error
    put_entry(16'h0100 + 64, 0, 0, 0, 3, 16'h0300);
    err_mode = 1;
    w0 = wr_cnt; i0 = irq_cnt;
    run(4, 1'b0);
    chk(wr_cnt == w0, "R12 read error no write", wr_cnt - w0, 0);
    chk(irq_cnt == i0, "R12 read error no irq", irq_cnt - i0, 0);

    // R12: write error on P byte
    err_mode = 2;
    w0 = wr_cnt; i0 = irq_cnt;
    run(4, 1'b0);
    chk(wr_cnt == w0 + 1, "R12 write attempted", wr_cnt - w0, 1);
    chk(irq_cnt == i0, "R12 write error no irq", irq_cnt - i0, 0);
    err_mode = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule